// File: doc/BRIEF.md
# Receive Byte Queue with Hardware Request-to-Send

This block sits between a serial receiver and the host read port. Bytes arriving from the receiver go into a 64-entry first-in first-out store. The host takes them out with a one-cycle pop strobe. The oldest stored byte is always visible on the read data output while the queue is not empty. The block reports the fill count, empty and full flags, and a one-cycle overrun pulse when a byte arrives with no room left.

The active-low request-to-send output is produced in hardware from the amount of free space. While automatic flow control is enabled, the far end may send when plenty of room remains and must stop when room runs short. Exactly half-free keeps the previous state, which gives hysteresis. While automatic flow control is disabled, the output follows a software request bit instead. A synchronous flush strobe discards the queue contents without a reset.

Top module: `rxq_flowctl`

## Requirements
- R1: Bytes leave the queue in the order they were written, and up to DEPTH (64) bytes can be held. `rd_data_o` shows the oldest byte whenever `empty_o` is 0.
- R2: `count_o` equals the number of stored bytes after each clock edge and never exceeds DEPTH. `empty_o` is 1 exactly when the count is 0, and `full_o` is 1 exactly when the count is DEPTH.
- R3: A write while `full_o` is 1 is dropped, even if a pop happens in the same cycle. The stored bytes and their order are unchanged, and `overrun_o` is 1 for exactly the one cycle after that write.
- R4: A write and a pop in the same cycle, with the queue neither empty nor full, leave `count_o` unchanged and advance the head.
- R5: A pop while the queue is empty has no effect on the count, the flags or the contents.
- R6: With `afc_en_i`=1, `rts_n_o` is 0 (asserted) one cycle after any cycle in which more than RTS_LEVEL (32) entries are free.
- R7: With `afc_en_i`=1, `rts_n_o` is 1 (deasserted) one cycle after any cycle in which fewer than RTS_LEVEL entries are free.
- R8: With `afc_en_i`=1, a cycle with exactly RTS_LEVEL free entries leaves `rts_n_o` at its previous value.
- R9: A `flush_i` strobe empties the queue at the next edge and overrides a same-cycle write or pop. It clears `overrun_o` and resets the automatic request to asserted (0).
- R10: With `afc_en_i`=0, `rts_n_o` is the inverse of `sw_rts_req_i` in the same cycle. The automatic state keeps tracking the count, so re-enabling picks up the current level.
- R11: After reset the queue is empty with count 0, `overrun_o` is 0 and the automatic request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard all stored bytes |
| wr_en_i | input | 1 | Receiver byte valid |
| wr_data_i | input | 8 | Receiver byte |
| rd_pop_i | input | 1 | Host pop strobe |
| rd_data_o | output | 8 | Oldest stored byte |
| count_o | output | 7 | Number of stored bytes |
| empty_o | output | 1 | Queue holds no byte |
| full_o | output | 1 | Queue holds DEPTH bytes |
| overrun_o | output | 1 | One-cycle pulse after a dropped write |
| afc_en_i | input | 1 | Automatic flow control enable |
| sw_rts_req_i | input | 1 | Software request bit used when automatic control is off |
| rts_n_o | output | 1 | Active-low request-to-send |

## Verification
The bench walks the fill level across the half-free boundary in both directions. A design without hysteresis would toggle the request at 32 stored bytes, and a design with the compare flipped would stop the sender while the queue is nearly empty. It writes into a full queue, with and without a simultaneous pop. A design that accepts such a byte would overwrite the oldest entry or report a wrong count. A design that misses the overrun pulse, or holds it longer than one cycle, is also caught. Simultaneous push and pop at several levels, pops on an empty queue, flushes with competing writes, and flow control toggled under traffic round out the directed cases. Seeded random traffic is checked against a queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Per-cycle queue operation decided by the control logic
    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } rxq_op_t;

    // Decision made by the free-space comparison
    typedef enum logic [1:0] {
        RTS_GO   = 2'd0,
        RTS_STOP = 2'd1,
        RTS_KEEP = 2'd2
    } rts_cmd_t;

    function automatic int free_slots(input int depth, input int used);
        return depth - used;
    endfunction

    function automatic rts_cmd_t rts_decide(input int free, input int level);
        if (free > level)
            return RTS_GO;
        else if (free < level)
            return RTS_STOP;
        else
            return RTS_KEEP;
    endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_req,
    input  logic          rd_req,
    output rxq_op_t       op,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          overrun
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // Flush wins over everything; a write into a full queue is dropped
    // regardless of a same-cycle pop.
    always_comb begin
        op.push = wr_req & ~full  & ~flush;
        op.pop  = rd_req & ~empty & ~flush;
        op.drop = wr_req &  full  & ~flush;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= op.drop;
            if (op.push)
                wr_ptr <= wr_ptr + AW'(1);
            if (op.pop)
                rd_ptr <= rd_ptr + AW'(1);
            unique case ({op.push, op.pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_rts_gen.sv
module rxq_rts_gen
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int RTS_LEVEL = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic          afc_en,
    input  logic          sw_req,
    output logic          rts_n
);

    rts_cmd_t cmd;
    logic     auto_rts_n;

    always_comb begin
        cmd = rts_decide(free_slots(DEPTH, int'(count)), RTS_LEVEL);
    end

    // Automatic state runs regardless of the enable so that switching
    // the enable on shows the current fill level.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            auto_rts_n <= 1'b0;
        end else begin
            unique case (cmd)
                RTS_GO:   auto_rts_n <= 1'b0;
                RTS_STOP: auto_rts_n <= 1'b1;
                default:  auto_rts_n <= auto_rts_n;
            endcase
        end
    end

    assign rts_n = afc_en ? auto_rts_n : ~sw_req;

endmodule

// File: rtl/rxq_flowctl.sv
module rxq_flowctl
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WIDTH     = 8,
    parameter int RTS_LEVEL = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_pop_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic [CW-1:0]    count_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             overrun_o,
    input  logic             afc_en_i,
    input  logic             sw_rts_req_i,
    output logic             rts_n_o
);

    rxq_op_t       op;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_i),
        .wr_req  (wr_en_i),
        .rd_req  (rd_pop_i),
        .op      (op),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count_o),
        .empty   (empty_o),
        .full    (full_o),
        .overrun (overrun_o)
    );

    rxq_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk   (clk),
        .we    (op.push),
        .waddr (wr_ptr),
        .wdata (wr_data_i),
        .raddr (rd_ptr),
        .rdata (rd_data_o)
    );

    rxq_rts_gen #(.DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_rts (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush_i),
        .count  (count_o),
        .afc_en (afc_en_i),
        .sw_req (sw_rts_req_i),
        .rts_n  (rts_n_o)
    );

endmodule

// File: rtl/rxq_flowctl_sva.sv
module rxq_flowctl_sva #(
    parameter int DEPTH     = 64,
    parameter int RTS_LEVEL = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          flush_i,
    input logic          wr_en_i,
    input logic          rd_pop_i,
    input logic [CW-1:0] count_o,
    input logic          empty_o,
    input logic          full_o,
    input logic          overrun_o,
    input logic          afc_en_i,
    input logic          rts_n_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH - RTS_LEVEL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_o <= FULL_CNT); // R2

    AST_OVR_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && full_o && !rd_pop_i && !flush_i) |=> (overrun_o && count_o == FULL_CNT)); // R3

    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i || flush_i) |=> !overrun_o); // R3

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && rd_pop_i && !full_o && !empty_o && !flush_i) |=> $stable(count_o)); // R4

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (rd_pop_i && empty_o && !wr_en_i && !flush_i) |=> empty_o); // R5

    AST_RTS_GO: assert property (@(posedge clk) disable iff (rst)
        (count_o < HALF_CNT && !flush_i) |=> (!afc_en_i || !rts_n_o)); // R6

    AST_RTS_STOP: assert property (@(posedge clk) disable iff (rst)
        (count_o > HALF_CNT && !flush_i) |=> (!afc_en_i || rts_n_o)); // R7

    AST_RTS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (count_o == HALF_CNT && !flush_i && afc_en_i) |=> (!afc_en_i || rts_n_o == $past(rts_n_o))); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (empty_o && count_o == '0 && !overrun_o && (!afc_en_i || !rts_n_o))); // R9

endmodule

bind rxq_flowctl rxq_flowctl_sva #(.DEPTH(DEPTH), .RTS_LEVEL(RTS_LEVEL)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .flush_i   (flush_i),
    .wr_en_i   (wr_en_i),
    .rd_pop_i  (rd_pop_i),
    .count_o   (count_o),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .overrun_o (overrun_o),
    .afc_en_i  (afc_en_i),
    .rts_n_o   (rts_n_o)
);

// File: tb/rxq_flowctl_test.sv
`timescale 1ns/1ps
module rxq_flowctl_test;

    localparam int DEPTH = 64;
    localparam int LEVEL = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flush_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_pop_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [6:0] count_o;
    logic       empty_o;
    logic       full_o;
    logic       overrun_o;
    logic       afc_en_i = 1'b1;
    logic       sw_rts_req_i = 1'b0;
    logic       rts_n_o;

    rxq_flowctl uut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_pop_i(rd_pop_i), .rd_data_o(rd_data_o),
        .count_o(count_o), .empty_o(empty_o), .full_o(full_o),
        .overrun_o(overrun_o), .afc_en_i(afc_en_i),
        .sw_rts_req_i(sw_rts_req_i), .rts_n_o(rts_n_o)
    );

    always #4 clk = ~clk;

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 0;
    logic [7:0] mq[$];
    logic       m_auto  = 1'b0;
    logic       m_ovr   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_rts();
        return afc_en_i ? m_auto : ~sw_rts_req_i;
    endfunction

    // Model update from the state before the edge
    function automatic void model_step(input logic wr, input logic [7:0] d,
                                       input logic pop, input logic fl);
        int used = mq.size();
        int free = DEPTH - used;
        if (fl) begin
            mq.delete();
            m_ovr  = 1'b0;
            m_auto = 1'b0;
        end else begin
            m_ovr = wr && (used == DEPTH);
            if (free > LEVEL)      m_auto = 1'b0;
            else if (free < LEVEL) m_auto = 1'b1;
            if (pop && used > 0) void'(mq.pop_front());
            if (wr && used < DEPTH) mq.push_back(d);
        end
    endfunction

    task automatic check_all(input string ctx);
        chk({ctx, " R2 count"}, 32'(count_o), 32'(mq.size()));
        chk({ctx, " R2 empty"}, 32'(empty_o), 32'(mq.size() == 0));
        chk({ctx, " R2 full"},  32'(full_o),  32'(mq.size() == DEPTH));
        if (mq.size() > 0)
            chk({ctx, " R1 head"}, 32'(rd_data_o), 32'(mq[0]));
        chk({ctx, " R3 overrun"}, 32'(overrun_o), 32'(m_ovr));
        if (afc_en_i)
            chk({ctx, " R6/R7/R8 rts"}, 32'(rts_n_o), 32'(exp_rts()));
        else
            chk({ctx, " R10 rts"}, 32'(rts_n_o), 32'(exp_rts()));
    endtask

    task automatic step(input logic wr, input logic [7:0] d, input logic pop,
                        input logic fl, input string ctx);
        @(negedge clk);
        wr_en_i = wr; wr_data_i = d; rd_pop_i = pop; flush_i = fl;
        model_step(wr, d, pop, fl);
        @(posedge clk);
        #2;
        check_all(ctx);
    endtask

    task automatic idle(input int n, input string ctx);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, ctx);
    endtask

    task automatic fill_to(input int target, input string ctx);
        while (mq.size() < target) step(1'b1, 8'($urandom), 1'b0, 1'b0, ctx);
        while (mq.size() > target) step(1'b0, 8'h00, 1'b1, 1'b0, ctx);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11 count", 32'(count_o), 0);
        chk("R11 empty", 32'(empty_o), 1);
        chk("R11 overrun", 32'(overrun_o), 0);
        chk("R11 rts", 32'(rts_n_o), 0);

        // R1 and R2: fill to capacity with random bytes
        fill_to(DEPTH, "R1 fill");

        // R3: writes into a full queue are dropped
        step(1'b1, 8'hA5, 1'b0, 1'b0, "R3 full write");
        step(1'b1, 8'h5A, 1'b0, 1'b0, "R3 full write");
        step(1'b0, 8'h00, 1'b0, 1'b0, "R3 pulse ends");
        step(1'b1, 8'h3C, 1'b1, 1'b0, "R3 full write with pop");

        // R1: drain and check order
        fill_to(0, "R1 drain");

        // R5: pops on an empty queue
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R5 empty pop");

        // R6, R7, R8: hysteresis around the half-free point
        fill_to(DEPTH - LEVEL, "R8 rise to half");
        idle(3, "R8 hold low at half");
        fill_to(DEPTH - LEVEL + 1, "R7 above half");
        idle(2, "R7 stopped");
        fill_to(DEPTH - LEVEL, "R8 back to half");
        idle(3, "R8 hold high at half");
        fill_to(DEPTH - LEVEL - 1, "R6 below half");
        idle(2, "R6 go");

        // R4: simultaneous push and pop at several levels
        for (int lvl = 1; lvl < DEPTH; lvl += 13) begin
            fill_to(lvl, "R4 level");
            for (int i = 0; i < 5; i++) step(1'b1, 8'($urandom), 1'b1, 1'b0, "R4 push pop");
        end

        // R10: software request with automatic control off
        afc_en_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            sw_rts_req_i = 1'($urandom);
            step(1'($urandom), 8'($urandom), 1'($urandom), 1'b0, "R10 sw");
        end
        fill_to(50, "R10 high level");
        afc_en_i = 1'b1;
        idle(2, "R10 reenable");

        // R9: flush with a competing write and pop
        step(1'b1, 8'h11, 1'b1, 1'b1, "R9 flush");
        idle(2, "R9 after flush");
        fill_to(DEPTH, "R9 refill");
        step(1'b1, 8'h22, 1'b0, 1'b0, "R9 overrun before flush");
        step(1'b0, 8'h00, 1'b0, 1'b1, "R9 flush clears overrun");

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic w = ($urandom % 100) < 55;
            logic p = ($urandom % 100) < 45;
            logic f = ($urandom % 400) == 0;
            if (($urandom % 200) == 0) afc_en_i = ~afc_en_i;
            if (($urandom % 20) == 0) sw_rts_req_i = ~sw_rts_req_i;
            step(w, 8'($urandom), p, f, "R1/R2/R3/R4/R6/R7 random");
        end
        for (int i = 0; i < 2000; i++)
            step(($urandom % 100) < 75, 8'($urandom), ($urandom % 100) < 40, 1'b0,
                 "R3/R8 random high");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule